// File: doc/BRIEF.md
# Receive Interrupt Delay Timer

This block holds back the receive interrupt until packet traffic pauses. Each time a packet has been fully written to memory, a countdown is loaded with a programmed delay. A packet that completes before the countdown ends loads it again, so a steady stream of packets postpones the interrupt. When the countdown runs out, the block asks the descriptor logic to write back any descriptors it is still holding and raises a receive-timer interrupt cause. Both requests appear together as a one-cycle pulse.

Software can force the timer to expire at once with a flush command. A separate absolute timer, which lies outside this block, reports its own expiry. That event cancels any pending delay interrupt and leaves the countdown reloaded but stopped until the next packet. The countdown moves only on cycles where the tick enable is high, so the time base is chosen outside the block.

Top module: `rx_irq_delay_timer`

## Requirements
- R1: After reset the timer is stopped, and both outputs stay low until an event causes a pulse.
- R2: A packet-done pulse with a non-zero delay D loads the countdown and starts it. Exactly D tick cycles later, with no other event in between, the cycle after the D-th tick carries one high cycle on both outputs, and the timer then stops.
- R3: A packet-done pulse while the countdown is running reloads it with the current delay, and the expiry moves to D ticks after that packet.
- R4: A packet-done pulse with a delay of zero produces the output pulse in the next cycle and leaves the timer stopped.
- R5: A flush-command write produces the output pulse in the next cycle whatever the timer state, and leaves the timer stopped. Each write gives exactly one pulse, because the command does not persist after it is taken.
- R6: An absolute-timer pulse stops the countdown without any output, even if it arrives in the same cycle as the final tick. Later ticks then produce nothing.
- R7: After a cancel by the absolute timer, the next packet-done pulse starts a full countdown that expires normally.
- R8: When a packet-done pulse arrives in the same cycle as the final tick, the expiry pulse is still produced and the countdown is reloaded for the new packet.
- R9: While the timer is stopped, ticks alone never produce an output pulse.
- R10: The flush request and the interrupt cause are always high in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pkt_done_i | input | 1 | One-cycle pulse: a packet has been completed to memory |
| delay_i | input | 16 | Programmed delay in ticks |
| flush_wr_i | input | 1 | One-cycle pulse: software wrote the flush command |
| abs_expire_i | input | 1 | One-cycle pulse: the absolute timer fired |
| tick_i | input | 1 | Countdown enable, one cycle per time unit |
| flush_req_o | output | 1 | Pulse asking for pending descriptor write-backs to be flushed |
| irq_cause_o | output | 1 | Pulse setting the receive-timer interrupt cause |

## Verification
The embedded properties watch, on every cycle, that a flush write or a zero-delay packet is followed by a pulse, that an absolute-timer event with no packet or flush is followed by silence, that a stopped timer stays quiet, and that a running countdown never holds zero. Only the bench's scenarios can show how a pulse lines up with a chain of earlier events. These include a restart moving the expiry by the full delay, a packet landing on the final tick, and a countdown resuming after a cancel. The bench checks these against a cycle model driven by mixed random and directed traffic.

// File: rtl/rx_irq_delay_pkg.sv
// Package: shared widths and types for the receive interrupt delay timer.
// Assumes: the delay field is a plain unsigned tick count.
package rx_irq_delay_pkg;
    parameter int unsigned DLY_W = 16;
    typedef logic [DLY_W-1:0] dly_t;
endpackage

// File: rtl/rxd_down_counter.sv
// Module: countdown register with a run flag.
// Loads the delay and runs, loads the delay and stops, or decrements on a tick.
// Assumes: load_run and load_stop are never high together, and the caller
// stops the counter when it reaches its final tick.
module rxd_down_counter
    import rx_irq_delay_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_run,
    input  logic load_stop,
    input  logic tick,
    input  dly_t delay,
    output logic running,
    output logic at_one
);
    dly_t cnt;

    // Count state: the loads take priority over the decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load_run) begin
            cnt     <= delay;
            running <= 1'b1;
        end else if (load_stop) begin
            cnt     <= delay;
            running <= 1'b0;
        end else if (running && tick) begin
            cnt <= cnt - 1'b1;
        end
    end

    // The last tick is pending when the count reaches one.
    always_comb at_one = (cnt == dly_t'(1));

    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        load_run |=> (running && cnt == $past(delay)));
    a_r6_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        load_stop |=> !running);
    a_r2_never_zero_running: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt != '0));
endmodule

// File: rtl/rxd_expiry_ctrl.sv
// Module: decides when the timer fires and registers the output pulses.
// It fires on a flush write, on a packet with zero delay, or on the final
// tick of a running countdown that is not cancelled by the absolute timer.
// Assumes: all event inputs are one-cycle pulses.
module rxd_expiry_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_done,
    input  logic delay_nz,
    input  logic flush_wr,
    input  logic abs_expire,
    input  logic tick,
    input  logic running,
    input  logic at_one,
    output logic load_run,
    output logic load_stop,
    output logic flush_req,
    output logic irq_cause
);
    logic final_tick;
    logic fire;

    // Fire decision and counter commands for this cycle.
    always_comb begin
        final_tick = running && tick && at_one;
        fire       = flush_wr || (pkt_done && !delay_nz) || (final_tick && !abs_expire);
        load_run   = pkt_done && delay_nz;
        load_stop  = !load_run && (pkt_done || abs_expire || fire);
    end

    // Output pulses, registered one cycle after the decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_req <= 1'b0;
            irq_cause <= 1'b0;
        end else begin
            flush_req <= fire;
            irq_cause <= fire;
        end
    end

    a_r5_flush_fires: assert property (@(posedge clk) disable iff (!rst_n)
        flush_wr |=> (irq_cause && flush_req));
    a_r4_zero_delay_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && !delay_nz) |=> irq_cause);
    a_r6_abs_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (abs_expire && !flush_wr && !pkt_done) |=> !irq_cause);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !flush_wr && !pkt_done) |=> (!irq_cause && !flush_req));
endmodule

// File: rtl/rx_irq_delay_timer.sv
// Module: receive interrupt delay timer (top).
// Re-arms on every completed packet, expires into a paired flush/interrupt
// pulse, can be forced by a flush write and is stopped by the absolute timer.
// Assumes: tick_i sets the time base; all event inputs are single-cycle pulses.
module rx_irq_delay_timer
    import rx_irq_delay_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_done_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic             flush_wr_i,
    input  logic             abs_expire_i,
    input  logic             tick_i,
    output logic             flush_req_o,
    output logic             irq_cause_o
);
    logic running, at_one, load_run, load_stop, delay_nz;

    // Zero delay means an immediate interrupt for each packet.
    always_comb delay_nz = (delay_i != '0);

    rxd_down_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .load_run(load_run), .load_stop(load_stop),
        .tick(tick_i), .delay(delay_i), .running(running), .at_one(at_one)
    );

    rxd_expiry_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done_i), .delay_nz(delay_nz),
        .flush_wr(flush_wr_i), .abs_expire(abs_expire_i), .tick(tick_i),
        .running(running), .at_one(at_one), .load_run(load_run),
        .load_stop(load_stop), .flush_req(flush_req_o), .irq_cause(irq_cause_o)
    );

    a_r10_outputs_paired: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req_o == irq_cause_o);
endmodule

// File: tb/rx_irq_delay_timer_test.sv
`timescale 1ns/1ps
module rx_irq_delay_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt = 1'b0, flush = 1'b0, abs_e = 1'b0, tick = 1'b0;
    logic [15:0] dly = '0;
    logic        freq, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state, built from the requirements.
    bit          m_run = 1'b0;
    int unsigned m_cnt = 0;
    bit          exp_out = 1'b0;
    string       exp_tag = "R1";
    bit          restarted = 1'b0;
    bit          cancelled = 1'b0;

    always #2.5 clk = ~clk;

    rx_irq_delay_timer uut (
        .clk(clk), .rst_n(rst_n), .pkt_done_i(pkt), .delay_i(dly),
        .flush_wr_i(flush), .abs_expire_i(abs_e), .tick_i(tick),
        .flush_req_o(freq), .irq_cause_o(irq)
    );

    // Expected pulse for the inputs of this cycle, per R2, R4, R5, R6.
    function automatic bit model_fire(bit p, int unsigned d, bit f, bit a, bit t);
        return f || (p && d == 0) || (m_run && t && m_cnt == 1 && !a);
    endfunction

    task automatic check(string tag, bit act_i, bit act_f, bit expv);
        checks++;
        if (act_i !== expv || act_f !== expv) begin
            errors++;
            $display("FAIL %s irq=%0b flush=%0b expected=%0b", tag, act_i, act_f, expv);
        end
    endtask

    // One cycle: check outputs at the falling edge, then advance the model and drive.
    task automatic step(bit p, int unsigned d, bit f, bit a, bit t);
        bit fire_now;
        @(negedge clk);
        check(exp_tag, irq, freq, exp_out);
        fire_now = model_fire(p, d, f, a, t);
        if (f) exp_tag = "R5";
        else if (p && d == 0) exp_tag = "R4";
        else if (fire_now && p) exp_tag = "R8";
        else if (fire_now && cancelled) exp_tag = "R7";
        else if (fire_now && restarted) exp_tag = "R3";
        else if (fire_now) exp_tag = "R2";
        else if (a) exp_tag = "R6";
        else if (!m_run) exp_tag = "R9";
        else exp_tag = "R2";
        if (fire_now) begin cancelled = 1'b0; restarted = 1'b0; end
        if (p && d != 0) begin
            if (m_run) restarted = 1'b1;
            m_run = 1'b1; m_cnt = d;
        end else if (p || a || fire_now) begin
            if (a && !fire_now && m_run) cancelled = 1'b1;
            m_run = 1'b0; m_cnt = d;
        end else if (m_run && t) begin
            m_cnt = m_cnt - 1;
        end
        exp_out = fire_now;
        pkt = p; dly = 16'(d); flush = f; abs_e = a; tick = t;
    endtask

    task automatic idle_ticks(int n);
        for (int i = 0; i < n; i++) step(0, dly, 0, 0, 1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1", irq, freq, 1'b0);
        rst_n = 1'b1;
        exp_tag = "R1"; exp_out = 1'b0;
        // R9: ticks with the timer stopped stay quiet
        idle_ticks(4);
        // R2: delay 3 expires after three ticks
        step(1, 3, 0, 0, 0); idle_ticks(5);
        // R3: restart before expiry
        step(1, 4, 0, 0, 1); idle_ticks(2); step(1, 4, 0, 0, 0); idle_ticks(6);
        // R4: zero delay
        step(1, 0, 0, 0, 1); idle_ticks(3);
        // R5: flush while stopped and while running, one pulse per write
        step(0, 5, 1, 0, 0); step(0, 5, 0, 0, 0); step(0, 5, 0, 0, 0);
        step(1, 5, 0, 0, 1); step(0, 5, 1, 0, 0); idle_ticks(7);
        // R6 then R7: cancel on the final tick, then restart
        step(1, 2, 0, 0, 0); step(0, 2, 0, 0, 1); step(0, 2, 0, 1, 1); idle_ticks(4);
        step(1, 2, 0, 0, 0); idle_ticks(4);
        // R8: packet on the final tick
        step(1, 2, 0, 0, 0); step(0, 2, 0, 0, 1); step(1, 2, 0, 0, 1); idle_ticks(4);
        // Random traffic, all requirements through the model (R10 on every check)
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 10) == 0, $urandom % 6, ($urandom % 40) == 0,
                 ($urandom % 25) == 0, ($urandom % 2) == 0);
        end
        idle_ticks(8);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule